// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Block

This block is the register window of one channel of a bus-mastering disk controller. It holds eight bytes: a command byte, a status byte, two reserved bytes and a 32-bit pointer to the descriptor table. Software reaches these bytes through a simple register bus that carries address, access size, write data and read data. The block decodes each write, applies the side effects that go with it, and sends single-cycle start and abort pulses to the transfer engine that sits beside it.

The transfer engine reports back over two pulses. The first marks a finished transfer. It stops the channel and raises the interrupt flag. The second marks a failed transfer and raises the error flag. Software clears both flags by writing a one to them. It cannot set either flag. Once a transfer is running, the direction bit can no longer be changed, and the active flag can only be changed by the start and stop actions.

Top module: `bmdma_regs`

## Requirements
- R1: Out of reset the command byte is 0x00, the status byte is 0x60 (the two capability bits, status bits 6 and 5, are 1) and the pointer is 0.
- R2: Only three writes are legal. A byte write (size code 0) to offset 0 or offset 2 is legal. A 4-byte write (size code 2) to offset 4 is legal. A byte write to offset 1 or offset 3 is also accepted and ignored. Any other write, including one with size code 3, changes no state and raises `wrErr` for exactly the cycle after the write.
- R3: A pointer write stores the written value with its two low bits forced to 0. The stored value is visible on `dmaPtr` and at offsets 4 to 7.
- R4: While the run bit (command bit 0) is 1, a command write leaves the direction bit (command bit 3) unchanged.
- R5: A command write that takes the run bit from 0 to 1 sets the active bit (status bit 0). In the following cycle it pulses `dmaStart`, with `dmaPtr` holding the current pointer.
- R6: A command write that takes the run bit from 1 to 0 clears the active bit. In the following cycle it pulses `dmaAbort`. A command write that leaves the run bit unchanged pulses neither output.
- R7: A status write never changes the active bit. Status bits 6 and 5 take the written value.
- R8: The interrupt bit (status bit 2) is cleared by writing 1 to it. Writing 0 leaves it unchanged. Software can never set it.
- R9: The error bit (status bit 1) is set by a `dmaFail` pulse. Software clears it under the same write-one-to-clear rule as the interrupt bit.
- R10: A `dmaDone` pulse clears the run bit and the active bit and sets the interrupt bit.
- R11: If `dmaDone` arrives in the same cycle as a write of 1 to the interrupt bit, the interrupt bit stays set.
- R12: Reads are combinational and little-endian. They return 1, 2 or 4 bytes (size codes 0, 1, 2) starting at `busAddr`. An access that reaches past byte 7, or that uses size code 3, reads 0. Reserved bytes and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe for one cycle |
| busAddr | input | 3 | Byte offset in the window |
| busSize | input | 2 | Access size code: 0=1, 1=2, 2=4 bytes, 3=invalid |
| busWrData | input | 32 | Write data, right-aligned |
| busRdData | output | 32 | Read data for busAddr/busSize |
| wrErr | output | 1 | Pulse: the previous write was illegal |
| dmaStart | output | 1 | Pulse: launch a transfer |
| dmaAbort | output | 1 | Pulse: abort the transfer |
| dmaPtr | output | 32 | Descriptor table pointer |
| dmaDone | input | 1 | Pulse from the engine: transfer finished |
| dmaFail | input | 1 | Pulse from the engine: transfer failed |

## Verification
Every offset and size combination is read at several points: after reset, after pointer writes with dense and sparse bit patterns, and at the end. These reads show whether byte lanes are misordered or whether the out-of-window rule is ignored. Every illegal offset and size pair is also written, followed by a readback of the whole window, which shows whether a rejected write leaked into state. The command byte is driven through every run-bit transition and with both direction values, so launches, aborts and silent rewrites can be told apart. Status writes are tried with each flag clear and set, and with each written 0 or 1, plus a completion landing in the same cycle as a clear, which separates write-one-to-clear from plain writes and shows the priority order.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int DATA_W = 32;
  localparam logic [2:0] OFF_CMD  = 3'd0;
  localparam logic [2:0] OFF_STAT = 3'd2;
  localparam logic [2:0] OFF_PTR  = 3'd4;

  localparam int CMD_RUN  = 0;
  localparam int CMD_DIR  = 3;
  localparam int ST_ACT   = 0;
  localparam int ST_ERR   = 1;
  localparam int ST_INT   = 2;
  localparam int ST_CAP_LO = 5;
  localparam int ST_CAP_HI = 6;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } accSize_e;

  typedef struct packed {
    logic cmdWr;
    logic statWr;
    logic ptrWr;
    logic startGo;
    logic abortGo;
    logic badWr;
  } regStrobe_t;
endpackage

// File: rtl/bmdma_ctrl.sv
module bmdma_ctrl
  import bmdma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWrEn,
  input  logic [2:0] busAddr,
  input  logic [1:0] busSize,
  input  logic       wrRun,
  input  logic       runQ,
  input  logic       dmaDone,
  output regStrobe_t strb,
  output logic       wrErr,
  output logic       dmaStart,
  output logic       dmaAbort
);
  logic isByte, isWord;
  logic hitCmd, hitStat, hitPtr, hitRsv;

  always_comb begin
    isByte  = (busSize == SZ_BYTE);
    isWord  = (busSize == SZ_WORD);
    hitCmd  = isByte && (busAddr == OFF_CMD);
    hitStat = isByte && (busAddr == OFF_STAT);
    hitPtr  = isWord && (busAddr == OFF_PTR);
    hitRsv  = isByte && ((busAddr == 3'd1) || (busAddr == 3'd3));

    strb.cmdWr   = busWrEn && hitCmd;
    strb.statWr  = busWrEn && hitStat;
    strb.ptrWr   = busWrEn && hitPtr;
    strb.badWr   = busWrEn && !(hitCmd || hitStat || hitPtr || hitRsv);
    // a completion in the same cycle overrides any run-bit edge
    strb.startGo = strb.cmdWr && !runQ && wrRun && !dmaDone;
    strb.abortGo = strb.cmdWr && runQ && !wrRun && !dmaDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrErr    <= 1'b0;
      dmaStart <= 1'b0;
      dmaAbort <= 1'b0;
    end else begin
      wrErr    <= strb.badWr;
      dmaStart <= strb.startGo;
      dmaAbort <= strb.abortGo;
    end
  end
endmodule

// File: rtl/bmdma_dp.sv
module bmdma_dp
  import bmdma_pkg::*;
#(
  parameter int ALIGN_BITS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [2:0]        busAddr,
  input  logic [1:0]        busSize,
  input  logic              dmaDone,
  input  logic              dmaFail,
  output logic              runQ,
  output logic              dirQ,
  output logic              actQ,
  output logic              errQ,
  output logic              intQ,
  output logic [DATA_W-1:0] ptrQ,
  output logic [DATA_W-1:0] busRdData
);
  localparam int WIN_W = 32 + DATA_W;
  localparam logic [DATA_W-1:0] PTR_MASK = ~((DATA_W'(1) << ALIGN_BITS) - DATA_W'(1));

  logic [1:0]       capQ;
  logic [7:0]       cmdByte, statByte;
  logic [WIN_W-1:0] win, shifted;
  logic [3:0]       nBytes, endByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ <= 1'b0;
      dirQ <= 1'b0;
      actQ <= 1'b0;
      errQ <= 1'b0;
      intQ <= 1'b0;
      capQ <= 2'b11;
      ptrQ <= '0;
    end else begin
      if (dmaDone)          runQ <= 1'b0;
      else if (strb.cmdWr)  runQ <= busWrData[CMD_RUN];

      if (strb.cmdWr && !runQ) dirQ <= busWrData[CMD_DIR];

      if (dmaDone)            actQ <= 1'b0;
      else if (strb.startGo)  actQ <= 1'b1;
      else if (strb.abortGo)  actQ <= 1'b0;

      if (dmaDone)                                intQ <= 1'b1;
      else if (strb.statWr && busWrData[ST_INT])  intQ <= 1'b0;

      if (dmaFail)                                errQ <= 1'b1;
      else if (strb.statWr && busWrData[ST_ERR])  errQ <= 1'b0;

      if (strb.statWr) capQ <= busWrData[ST_CAP_HI:ST_CAP_LO];
      if (strb.ptrWr)  ptrQ <= busWrData & PTR_MASK;
    end
  end

  always_comb begin
    cmdByte  = '0;
    cmdByte[CMD_RUN] = runQ;
    cmdByte[CMD_DIR] = dirQ;
    statByte = '0;
    statByte[ST_ACT] = actQ;
    statByte[ST_ERR] = errQ;
    statByte[ST_INT] = intQ;
    statByte[ST_CAP_HI:ST_CAP_LO] = capQ;
    win = {ptrQ, 8'h00, statByte, 8'h00, cmdByte};
    shifted = win >> {busAddr, 3'b000};
    unique case (busSize)
      SZ_BYTE: nBytes = 4'd1;
      SZ_HALF: nBytes = 4'd2;
      SZ_WORD: nBytes = 4'd4;
      default: nBytes = 4'd0;
    endcase
    endByte = {1'b0, busAddr} + nBytes;
    busRdData = '0;
    if (nBytes != 4'd0 && endByte <= 4'd8) begin
      unique case (busSize)
        SZ_BYTE: busRdData = {24'h0, shifted[7:0]};
        SZ_HALF: busRdData = {16'h0, shifted[15:0]};
        default: busRdData = shifted[31:0];
      endcase
    end
  end
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic [2:0]  busAddr,
  input  logic [1:0]  busSize,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  output logic        wrErr,
  output logic        dmaStart,
  output logic        dmaAbort,
  output logic [31:0] dmaPtr,
  input  logic        dmaDone,
  input  logic        dmaFail
);
  regStrobe_t strb;
  logic runQ, dirQ, actQ, errQ, intQ;

  bmdma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busSize(busSize), .wrRun(busWrData[CMD_RUN]), .runQ(runQ),
    .dmaDone(dmaDone), .strb(strb), .wrErr(wrErr),
    .dmaStart(dmaStart), .dmaAbort(dmaAbort)
  );

  bmdma_dp #(.ALIGN_BITS(2)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWrData(busWrData),
    .busAddr(busAddr), .busSize(busSize), .dmaDone(dmaDone),
    .dmaFail(dmaFail), .runQ(runQ), .dirQ(dirQ), .actQ(actQ),
    .errQ(errQ), .intQ(intQ), .ptrQ(dmaPtr), .busRdData(busRdData)
  );
endmodule

// File: rtl/bmdma_regs_chk.sv
module bmdma_regs_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busWrEn,
  input logic [2:0]  busAddr,
  input logic [1:0]  busSize,
  input logic [31:0] busWrData,
  input logic        wrErr,
  input logic        dmaStart,
  input logic        dmaAbort,
  input logic [31:0] dmaPtr,
  input logic        dmaDone,
  input logic        runQ,
  input logic        dirQ,
  input logic        actQ,
  input logic        intQ
);
  p_bad_size_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busSize == 2'd3) |=> wrErr);

  p_ptr_align_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 3'd4 && busSize == 2'd2)
      |=> (dmaPtr == ($past(busWrData) & 32'hFFFF_FFFC)));

  p_dir_frozen_r4: assert property (@(posedge clk) disable iff (!rstN)
    runQ |=> $stable(dirQ));

  p_start_active_r5: assert property (@(posedge clk) disable iff (!rstN)
    dmaStart |-> (actQ && runQ && !dmaAbort));

  p_abort_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    dmaAbort |-> (!actQ && !runQ));

  p_stat_keeps_act_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 3'd2 && !dmaDone) |=> $stable(actQ));

  p_no_sw_int_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!intQ && !dmaDone) |=> !intQ);

  p_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    dmaDone |=> (intQ && !actQ && !runQ));
endmodule

bind bmdma_regs bmdma_regs_chk u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .busSize(busSize), .busWrData(busWrData), .wrErr(wrErr),
  .dmaStart(dmaStart), .dmaAbort(dmaAbort), .dmaPtr(dmaPtr),
  .dmaDone(dmaDone), .runQ(runQ), .dirQ(dirQ), .actQ(actQ), .intQ(intQ)
);

// File: tb/bmdma_regs_bench.sv
module bmdma_regs_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [1:0]  busSize = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        wrErr, dmaStart, dmaAbort;
  logic [31:0] dmaPtr;
  logic        dmaDone = 1'b0;
  logic        dmaFail = 1'b0;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // expected state, kept from the requirements
  logic mRun = 0, mDir = 0, mAct = 0, mErr = 0, mInt = 0;
  logic [1:0] mCap = 2'b11;
  logic [31:0] mPtr = 0;

  always #4 clk = ~clk;

  bmdma_regs u_bmdma_regs (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busSize(busSize), .busWrData(busWrData), .busRdData(busRdData),
    .wrErr(wrErr), .dmaStart(dmaStart), .dmaAbort(dmaAbort),
    .dmaPtr(dmaPtr), .dmaDone(dmaDone), .dmaFail(dmaFail)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [2:0] a, input logic [1:0] s);
    logic [63:0] w;
    int nb;
    w = {mPtr, 8'h00, 1'b0, mCap, 2'b00, mInt, mErr, mAct, 8'h00, 4'b0000, mDir, 2'b00, mRun};
    nb = (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : (s == 2'd2) ? 4 : 0;
    if (nb == 0 || int'(a) + nb > 8) return 32'h0;
    w = w >> (int'(a) * 8);
    return (nb == 4) ? w[31:0] : (nb == 2) ? {16'h0, w[15:0]} : {24'h0, w[7:0]};
  endfunction

  task automatic rdChk(input string req, input logic [2:0] a, input logic [1:0] s);
    busAddr = a; busSize = s;
    #1;
    check(req, busRdData, expRead(a, s));
  endtask

  task automatic readSweep(input string req);
    for (int a = 0; a < 8; a++)
      for (int s = 0; s < 4; s++)
        rdChk(req, 3'(a), 2'(s));
  endtask

  task automatic wr(input logic [2:0] a, input logic [1:0] s, input logic [31:0] d);
    logic legal, eStart, eAbort;
    eStart = 0; eAbort = 0;
    legal = (s == 2'd0 && (a == 3'd0 || a == 3'd1 || a == 3'd2 || a == 3'd3)) ||
            (s == 2'd2 && a == 3'd4);
    @(negedge clk);
    busWrEn = 1; busAddr = a; busSize = s; busWrData = d;
    @(negedge clk);
    busWrEn = 0;
    if (legal && a == 3'd0 && s == 2'd0) begin
      eStart = !mRun && d[0];
      eAbort = mRun && !d[0];
      if (!mRun) mDir = d[3];
      mRun = d[0];
      if (eStart) mAct = 1;
      if (eAbort) mAct = 0;
    end else if (legal && a == 3'd2) begin
      mCap = d[6:5];
      if (d[2]) mInt = 0;
      if (d[1]) mErr = 0;
    end else if (legal && a == 3'd4) begin
      mPtr = d & 32'hFFFF_FFFC;
    end
    check("R2 wrErr", {31'h0, wrErr}, {31'h0, !legal});
    check("R5 dmaStart", {31'h0, dmaStart}, {31'h0, eStart});
    check("R6 dmaAbort", {31'h0, dmaAbort}, {31'h0, eAbort});
    if (eStart) check("R5 dmaPtr at start", dmaPtr, mPtr);
  endtask

  task automatic pulse(input logic done, input logic fail);
    @(negedge clk);
    dmaDone = done; dmaFail = fail;
    @(negedge clk);
    dmaDone = 0; dmaFail = 0;
    if (done) begin mRun = 0; mAct = 0; mInt = 1; end
    if (fail) mErr = 1;
  endtask

  initial begin
    logic [31:0] pats [6];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h1234_5677; pats[2] = 32'h0000_0000;
    pats[3] = 32'hA5A5_A5A6; pats[4] = 32'h8000_0001; pats[5] = 32'h1000_0ABE;

    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    busAddr = 3'd0; busSize = 2'd2; #1;
    check("R1 dword0", busRdData, 32'h0060_0000);
    busAddr = 3'd4; #1;
    check("R1 pointer", busRdData, 32'h0);
    check("R1 outputs", {29'h0, wrErr, dmaStart, dmaAbort}, 32'h0);
    readSweep("R12 reset sweep");

    // R3 pointer alignment
    foreach (pats[i]) begin
      wr(3'd4, 2'd2, pats[i]);
      check("R3 dmaPtr", dmaPtr, pats[i] & 32'hFFFF_FFFC);
      rdChk("R3 readback", 3'd4, 2'd2);
      readSweep("R12 sweep");
    end

    // R2 illegal writes leave all state intact
    for (int a = 0; a < 8; a++)
      for (int s = 0; s < 4; s++) begin
        if ((s == 0 && a < 4) || (s == 2 && a == 4)) continue;
        wr(3'(a), 2'(s), 32'hFFFF_FFFF);
        rdChk("R2 no change low", 3'd0, 2'd2);
        rdChk("R2 no change ptr", 3'd4, 2'd2);
      end
    wr(3'd1, 2'd0, 32'hFF);
    wr(3'd3, 2'd0, 32'hFF);
    rdChk("R12 reserved stays zero", 3'd0, 2'd2);

    // R5 start with direction 1
    wr(3'd0, 2'd0, 32'h09);
    rdChk("R5 active", 3'd2, 2'd0);
    // R4 direction frozen while running
    wr(3'd0, 2'd0, 32'h01);
    check("R4 dir held", expRead(3'd0, 2'd0), 32'h09);
    rdChk("R4 dir held", 3'd0, 2'd0);
    // R7 status writes keep active, caps writable
    wr(3'd2, 2'd0, 32'h00);
    rdChk("R7 active kept, caps cleared", 3'd2, 2'd0);
    wr(3'd2, 2'd0, 32'h61);
    rdChk("R7 caps restored", 3'd2, 2'd0);
    // R6 abort
    wr(3'd0, 2'd0, 32'h00);
    rdChk("R6 idle", 3'd0, 2'd2);
    wr(3'd0, 2'd0, 32'h08);
    rdChk("R4 dir free when idle", 3'd0, 2'd0);
    wr(3'd0, 2'd0, 32'h08);

    // R10 completion
    wr(3'd0, 2'd0, 32'h01);
    pulse(1, 0);
    rdChk("R10 after done", 3'd0, 2'd2);
    check("R10 status", expRead(3'd2, 2'd0), 32'h64);

    // R8 write-one-to-clear
    wr(3'd2, 2'd0, 32'h60);
    rdChk("R8 write 0 keeps int", 3'd2, 2'd0);
    wr(3'd2, 2'd0, 32'h64);
    rdChk("R8 write 1 clears int", 3'd2, 2'd0);
    wr(3'd2, 2'd0, 32'h64);
    rdChk("R8 software cannot set int", 3'd2, 2'd0);

    // R9 error flag
    pulse(0, 1);
    rdChk("R9 error set", 3'd2, 2'd0);
    wr(3'd2, 2'd0, 32'h60);
    rdChk("R9 write 0 keeps err", 3'd2, 2'd0);
    wr(3'd2, 2'd0, 32'h62);
    rdChk("R9 write 1 clears err", 3'd2, 2'd0);
    wr(3'd2, 2'd0, 32'h62);
    rdChk("R9 software cannot set err", 3'd2, 2'd0);

    // R11 completion beats a same-cycle clear
    wr(3'd0, 2'd0, 32'h01);
    @(negedge clk);
    busWrEn = 1; busAddr = 3'd2; busSize = 2'd0; busWrData = 32'h64; dmaDone = 1;
    @(negedge clk);
    busWrEn = 0; dmaDone = 0;
    mCap = 2'b11; mRun = 0; mAct = 0; mInt = 1;
    rdChk("R11 int stays set", 3'd2, 2'd0);
    check("R11 status", expRead(3'd2, 2'd0), 32'h64);
    readSweep("R12 final sweep");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule